// File: doc/BRIEF.md
# Probabilistic Looping Shift Register

This block is an eight-stage bit ring that produces stepped pseudo-random patterns. It moves forward by one position each time an external gate signal falls. The gate may arrive from any clock domain. The bit that leaves the top stage comes back in at stage 0. On the way it may be complemented, and a probability word sets how likely that is.

With a probability of zero the ring repeats its eight-step pattern without change. At the midpoint every new bit is effectively a coin toss. At full scale the returning bit is always complemented, so the pattern runs through a sixteen-step cycle: the pattern, then its complement. A seed strobe can overwrite the ring at any time.

Each stage is visible as its own output bit. A registered copy of all eight stages is also provided as a binary value, with stage 0 as the least significant bit.

Top module: `plsr_top`

## Requirements
- R1: While reset is low, the ring, the packed value and the random source all hold the nonzero constant SEED_INIT (default 8'h5B).
- R2: The gate passes through a two-flop synchronizer and then a falling-edge detector. A high-to-low gate transition makes `stage_q` change on the third rising clock edge after the new level is first sampled. A rising gate edge or a steady gate level never changes `stage_q`.
- R3: On a shift, stage k+1 takes the old stage k, and stage 0 takes the old stage 7 XOR the flip decision.
- R4: The flip decision is 1 when the current random byte, read as unsigned, is strictly less than `flip_prob`. The random byte advances on every clock after reset: it shifts left by one, and the new bit 0 is the XOR of old bits 7, 5, 4 and 3.
- R5: With `flip_prob` = 0, eight shifts return the ring to its starting pattern.
- R6: With `flip_prob` at 256 or above, every shift complements the returning bit. Eight shifts give the bitwise complement of the start, and sixteen shifts give the start again.
- R7: A high `seed_load` copies `seed_value` into the ring on that clock edge. This takes priority over a shift detected in the same cycle.
- R8: `level_o` equals `stage_q` as it was one clock earlier. It is therefore unchanged in the cycle in which `stage_q` moves, and it stays stable between shifts.
- R9: The random byte is never zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Strobe: overwrite the ring with `seed_value` |
| seed_value | input | 8 | Pattern loaded by `seed_load` |
| gate_in | input | 1 | Asynchronous step gate; the ring advances on its falling edge |
| flip_prob | input | 9 | Flip probability, 0 (never) to 256 (always) |
| stage_q | output | 8 | Ring contents, one bit per stage |
| level_o | output | 8 | Registered binary value of the ring, stage 0 as LSB |

## Verification
The embedded assertions check the following on every clock:
- the ring holds its value when neither a shift nor a load is active;
- the upper stages take their lower neighbours on a shift;
- the returning bit is kept at zero probability and complemented at full scale;
- a load overrides a shift;
- the packed value lags the ring by one cycle;
- the detector never reports two falls in a row;
- the random byte never reaches zero.

Some properties can only be seen through the bench's scenarios. These are the exact three-edge latency from gate to ring, the random flip sequence at intermediate probabilities, the eight- and sixteen-step loop closures, and the collision of a seed load with a detected fall. They are covered by a cycle-accurate behavioural model and by directed pulse trains.

// File: rtl/plsr_pkg.sv
package plsr_pkg;
  localparam int RND_W  = 8;
  localparam int PROB_W = RND_W + 1;

  typedef logic [RND_W-1:0]  rnd_t;
  typedef logic [PROB_W-1:0] prob_t;

  // Maximal-length step: taps 8,6,5,4 expressed as bits 7,5,4,3.
  function automatic rnd_t rnd_step(rnd_t s);
    return {s[RND_W-2:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  // Flip when the random byte falls strictly below the probability word.
  function automatic logic flip_decide(rnd_t r, prob_t p);
    return {1'b0, r} < p;
  endfunction
endpackage

// File: rtl/plsr_gate_sync.sv
module plsr_gate_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_in,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] chain;
  logic                   settled_w;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= gate_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign settled_w = chain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= settled_w;
  end

  assign fall_o = prev_q & ~settled_w;

  // R2: one falling edge yields exactly one single-cycle detect pulse
  a_r2_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o);
endmodule

// File: rtl/plsr_rng.sv
module plsr_rng
  import plsr_pkg::*;
#(
  parameter rnd_t SEED = 8'h5B
) (
  input  logic clk,
  input  logic rst_n,
  output rnd_t rnd_o
);
  rnd_t state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= rnd_step(state_q);
  end

  assign rnd_o = state_q;

  // R9: the random source never locks up at zero
  a_r9_rng_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_o != '0);
endmodule

// File: rtl/plsr_ring.sv
module plsr_ring #(
  parameter int               STAGES = 8,
  parameter logic [STAGES-1:0] SEED  = 8'h5B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [STAGES-1:0] seed_i,
  input  logic              shift_i,
  input  logic              invert_i,
  output logic [STAGES-1:0] stage_o
);
  logic [STAGES-1:0] ring_q;
  logic              entry_w;

  assign entry_w = ring_q[STAGES-1] ^ invert_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ring_q <= SEED;
    else if (load_i)  ring_q <= seed_i;
    else if (shift_i) ring_q <= {ring_q[STAGES-2:0], entry_w};
  end

  assign stage_o = ring_q;

  // R2: no shift and no load leaves the ring untouched
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !shift_i) |=> $stable(stage_o));

  // R3: upper stages take their lower neighbours on a shift
  a_r3_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !load_i) |=> stage_o[STAGES-1:1] == $past(stage_o[STAGES-2:0]));

  // R7: a load wins over a shift in the same cycle
  a_r7_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> stage_o == $past(seed_i));
endmodule

// File: rtl/plsr_top.sv
module plsr_top
  import plsr_pkg::*;
#(
  parameter int               STAGES      = 8,
  parameter int               SYNC_STAGES = 2,
  parameter logic [STAGES-1:0] SEED_INIT  = 8'h5B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [STAGES-1:0] seed_value,
  input  logic              gate_in,
  input  logic [PROB_W-1:0] flip_prob,
  output logic [STAGES-1:0] stage_q,
  output logic [STAGES-1:0] level_o
);
  localparam rnd_t  RNG_SEED  = rnd_t'(SEED_INIT);
  localparam prob_t FULL_PROB = prob_t'(1 << RND_W);

  logic shift_w;
  logic flip_w;
  rnd_t rnd_w;
  logic [STAGES-1:0] ring_w;
  logic [STAGES-1:0] level_q;

  plsr_gate_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_in(gate_in),
    .fall_o (shift_w)
  );

  plsr_rng #(.SEED(RNG_SEED)) u_rng (
    .clk  (clk),
    .rst_n(rst_n),
    .rnd_o(rnd_w)
  );

  assign flip_w = flip_decide(rnd_w, flip_prob);

  plsr_ring #(.STAGES(STAGES), .SEED(SEED_INIT)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (seed_load),
    .seed_i  (seed_value),
    .shift_i (shift_w),
    .invert_i(flip_w),
    .stage_o (ring_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= SEED_INIT;
    else        level_q <= ring_w;
  end

  assign stage_q = ring_w;
  assign level_o = level_q;

  // R5: at zero probability the returning bit is kept
  a_r5_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_w && !seed_load && flip_prob == '0) |=> stage_q[0] == $past(stage_q[STAGES-1]));

  // R6: at full scale the returning bit is always complemented
  a_r6_always_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_w && !seed_load && flip_prob >= FULL_PROB) |=> stage_q[0] != $past(stage_q[STAGES-1]));

  // R8: packed value lags the ring by one clock
  a_r8_packed_lag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> level_o == $past(stage_q));
endmodule

// File: tb/plsr_top_test.sv
`timescale 1ns/1ps
module plsr_top_test;
  localparam int SEED = 8'h5B;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       seed_load = 1'b0;
  logic [7:0] seed_value = 8'h00;
  logic       gate_in = 1'b0;
  logic [8:0] flip_prob = 9'd0;
  logic [7:0] stage_q;
  logic [7:0] level_o;

  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // behavioural model state
  int m_s1, m_s2, m_prev, m_rng, m_reg, m_pk;
  bit m_valid = 0;

  always #2.5 clk = ~clk;

  plsr_top uut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_value(seed_value),
    .gate_in(gate_in), .flip_prob(flip_prob), .stage_q(stage_q), .level_o(level_o)
  );

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle model: R1..R4, R7, R9 behaviour written with integers
  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0;
      m_rng = SEED; m_reg = SEED; m_pk = SEED;
    end else begin
      int fall_m, inv_m, fb;
      fall_m = (m_prev == 1 && m_s2 == 0) ? 1 : 0;
      inv_m  = (m_rng < int'(flip_prob)) ? 1 : 0;
      m_pk   = m_reg;
      if (seed_load) m_reg = int'(seed_value);
      else if (fall_m == 1) m_reg = ((m_reg * 2) % 256) + (((m_reg / 128) % 2) ^ inv_m);
      fb = ((m_rng >> 7) ^ (m_rng >> 5) ^ (m_rng >> 4) ^ (m_rng >> 3)) & 1;
      m_rng  = ((m_rng * 2) % 256) + fb;
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = int'(gate_in);
    end
    m_valid = 1;
  end

  always @(negedge clk) begin
    if (m_valid && !done) begin
      check("R2 R3 R4 R9 stage_q vs model", int'(stage_q), m_reg);
      check("R8 level_o vs model", int'(level_o), m_pk);
    end
  end

  task automatic pulse();
    @(negedge clk) gate_in = 1'b1;
    repeat (3) @(negedge clk);
    gate_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int s0, old;
    repeat (4) @(negedge clk);
    check("R1 reset stage_q", int'(stage_q), SEED);
    check("R1 reset level_o", int'(level_o), SEED);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: rising edge and steady high leave the ring alone
    s0 = int'(stage_q);
    gate_in = 1'b1;
    repeat (6) @(negedge clk);
    check("R2 rising edge no shift", int'(stage_q), s0);
    gate_in = 1'b0;
    repeat (4) @(negedge clk);

    // R5: locked loop
    flip_prob = 9'd0;
    s0 = int'(stage_q);
    repeat (8) pulse();
    check("R5 8-step loop closes", int'(stage_q), s0);

    // R6: inverting loop, also above full scale
    flip_prob = 9'd256;
    s0 = int'(stage_q);
    repeat (8) pulse();
    check("R6 half cycle complements", int'(stage_q), (~s0) & 255);
    repeat (8) pulse();
    check("R6 16-step loop closes", int'(stage_q), s0);
    flip_prob = 9'd300;
    repeat (8) pulse();
    check("R6 above full scale complements", int'(stage_q), (~s0) & 255);

    // R4: random and partial probabilities
    flip_prob = 9'd128;
    repeat (40) pulse();
    flip_prob = 9'd40;
    repeat (20) pulse();

    // R2 latency: third edge after sampling
    flip_prob = 9'd0;
    @(negedge clk) gate_in = 1'b1;
    repeat (3) @(negedge clk);
    old = int'(stage_q);
    gate_in = 1'b0;
    repeat (2) @(negedge clk);
    check("R2 no change before third edge", int'(stage_q), old);
    @(negedge clk);
    check("R2 shift on third edge", int'(stage_q), ((old * 2) % 256) + (old / 128));
    // R8: packed value still holds the old ring here
    check("R8 level lags shift", int'(level_o), old);
    @(negedge clk);
    check("R8 level follows next clock", int'(level_o), ((old * 2) % 256) + (old / 128));
    repeat (3) @(negedge clk);

    // R7: load collides with a detected fall
    gate_in = 1'b1;
    repeat (3) @(negedge clk);
    gate_in = 1'b0;
    repeat (2) @(negedge clk);
    seed_value = 8'hC3;
    seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    check("R7 load wins over shift", int'(stage_q), 8'hC3);
    repeat (4) @(negedge clk);
    check("R7 no late shift after load", int'(stage_q), 8'hC3);

    // R7: plain load
    seed_value = 8'h01;
    seed_load = 1'b1;
    @(negedge clk);
    seed_load = 1'b0;
    check("R7 plain load", int'(stage_q), 8'h01);

    // fast gate toggling at mid probability
    flip_prob = 9'd128;
    for (int k = 0; k < 30; k++) begin
      gate_in = 1'b1;
      repeat (2) @(negedge clk);
      gate_in = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (6) @(negedge clk);
    finish_run();
  end
endmodule